// File: doc/BRIEF.md
# Four-Bit Lookahead Carry Unit with Run-Time Fault Injection

This block computes the carries of a four-bit group from a carry-in and four generate/propagate pairs, all at once rather than by ripple. It yields the carries into bit positions 1, 2 and 3. It also yields a group generate and a group propagate, so that a higher-level lookahead stage can combine several groups. The arithmetic path is purely combinational.

Fifteen nodes of that path can be faulted while the block runs. These nodes are the carry-in, every generate and propagate input, one internal product term, and every output gate. Each one passes through a 2:1 multiplexer. One leg of the multiplexer carries the true node value. The other leg carries either a stuck constant or the output of a substituted gate.

A stuck-at-0 value is built as a signal ANDed with its own complement, and a stuck-at-1 value as a signal ORed with its complement. Gate substitution works as follows:
- OR gates behave as NOR.
- AND gates behave as OR.
- Input buffers behave as inverters.

The fault mode of each site sits in a small register that is written one site at a time through a plain control port. Any number of sites can be faulted at once, so the block can model single faults, multiple stuck-at faults and gate-replacement faults for diagnosis experiments.

Top module: `cla_fi_top`

## Requirements
- R1: With every site in mode 0, `carry_out[0]`=g0|p0&cin, `carry_out[1]`=g1|p1&g0|p1&p0&cin, `carry_out[2]`=g2|p2&g1|p2&p1&g0|p2&p1&p0&cin, for every input combination.
- R2: With every site in mode 0, `grp_prop` is the AND of the four propagate bits, and `grp_gen`=g3|p3&g2|p3&p2&g1|p3&p2&p1&g0.
- R3: Mode 1 (stuck-at-0) makes the selected site's node 0. Every output that depends on that node then follows from the equations with that node forced low.
- R4: Mode 2 (stuck-at-1) makes the selected site's node 1. Every output that depends on that node then follows from the equations with that node forced high.
- R5: Mode 3 (gate swap) replaces the site's gate with another gate type:
  - Carry sites 9–11 and group-generate site 13 become NOR.
  - Group-propagate site 12 and product-term site 14 (p1&g0, which feeds only carry 2) become OR.
  - Input sites 0–8 become inverters.
- R6: Several sites can hold non-zero modes at the same time, and their effects combine. For example, p0 and p3 stuck-at-1 together with g0 stuck-at-1.
- R7: A write with `cfg_wr`=1 on a rising clock edge stores `cfg_mode` for site `cfg_site`.
  - The site map is: 0=cin, 1–4=p0–p3, 5–8=g0–g3, 9–11=carry 1–3, 12=group propagate, 13=group generate, 14=term p1&g0.
  - The new mode takes effect on the outputs right after that edge.
  - A mode stays in force until it is rewritten, and writing mode 0 restores the true node.
- R8: While `rst_n` is low, every site mode is 0, and the outputs follow R1 and R2 at once.
- R9: A write to site address 15 changes no site mode, so the outputs stay fault-free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault-mode register |
| rst_n | input | 1 | Asynchronous active-low reset, clears all modes |
| cfg_wr | input | 1 | Write strobe for one site mode |
| cfg_site | input | 4 | Site index to write (0–14 valid) |
| cfg_mode | input | 2 | Mode: 0 none, 1 stuck-0, 2 stuck-1, 3 gate swap |
| carry_in | input | 1 | Group carry-in |
| gen_in | input | 4 | Bit generate signals g3..g0 |
| prop_in | input | 4 | Bit propagate signals p3..p0 |
| carry_out | output | 3 | Carries into bits 3..1 (bit 0 is carry 1) |
| grp_gen | output | 1 | Group generate for cascading |
| grp_prop | output | 1 | Group propagate for cascading |

## Verification
The bench sweeps all 512 input patterns with no faults, which catches a dropped or mis-ordered product term in any carry. It then faults every site in every mode in turn and drives random inputs. A wrong site decode would corrupt a different output than the one expected. A swap built as the wrong gate type, or a stuck value left undriven, would mismatch at once. Combined faults check that sites interact through the shared terms rather than override one another. Two further cases guard the register: a write to the spare address 15 must leave the outputs clean, which a decoder that wraps or aliases the address would fail. A reset in the middle of a faulted run must restore the clean outputs immediately, which a reset that waited for a clock edge would fail.

// File: rtl/cla_fi_pkg.sv
package cla_fi_pkg;
  localparam int NUM_SITES = 15;
  localparam int SITE_AW   = $clog2(NUM_SITES + 1);
  localparam int GRP_BITS  = 4;

  typedef enum logic [1:0] {
    FM_NONE = 2'd0,
    FM_SA0  = 2'd1,
    FM_SA1  = 2'd2,
    FM_SWAP = 2'd3
  } fault_mode_e;

  // site indices; the order is part of the control interface
  localparam int S_CIN  = 0;
  localparam int S_P0   = 1;
  localparam int S_G0   = S_P0 + GRP_BITS;
  localparam int S_C1   = S_G0 + GRP_BITS;
  localparam int S_GP   = S_C1 + 3;
  localparam int S_GG   = S_GP + 1;
  localparam int S_TERM = S_GG + 1;
endpackage

// File: rtl/cla_fi_site.sv
module cla_fi_site
  import cla_fi_pkg::*;
(
  input  logic        node_true,
  input  logic        node_swap,
  input  fault_mode_e mode,
  output logic        node_out
);
  logic stuck_lo, stuck_hi;

  // constants formed from the node itself, as a physical forced net would be
  assign stuck_lo = node_true & ~node_true;
  assign stuck_hi = node_true | ~node_true;

  always_comb begin
    case (mode)
      FM_SA0:  node_out = stuck_lo;
      FM_SA1:  node_out = stuck_hi;
      FM_SWAP: node_out = node_swap;
      default: node_out = node_true;
    endcase
  end
endmodule

// File: rtl/cla_fi_ctrl.sv
module cla_fi_ctrl
  import cla_fi_pkg::*;
#(
  parameter int SITES = NUM_SITES,
  parameter int AW    = SITE_AW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [AW-1:0]         cfg_site,
  input  logic [1:0]            cfg_mode,
  output logic [SITES-1:0][1:0] modes
);
  localparam logic [AW-1:0] LAST_SITE = AW'(SITES - 1);

  logic hit;
  assign hit = cfg_wr && (cfg_site <= LAST_SITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   modes <= '0;
    else if (hit) modes[cfg_site] <= cfg_mode;
  end

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> modes[$past(cfg_site)] == $past(cfg_mode));

  assert_modes_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(modes));

  assert_spare_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_site > LAST_SITE) |=> $stable(modes));
endmodule

// File: rtl/cla_fi_core.sv
module cla_fi_core
  import cla_fi_pkg::*;
#(
  parameter int SITES = NUM_SITES
) (
  input  logic                  cin,
  input  logic [GRP_BITS-1:0]   gen,
  input  logic [GRP_BITS-1:0]   prop,
  input  logic [SITES-1:0][1:0] modes,
  output logic [2:0]            carry,
  output logic                  ggen,
  output logic                  gprop
);
  logic                cin_f, term_f;
  logic [GRP_BITS-1:0] p_f, g_f;
  logic [2:0]          c_or;
  logic                gg_or, gp_and, gp_or;

  cla_fi_site u_cin (
    .node_true(cin), .node_swap(~cin),
    .mode(fault_mode_e'(modes[S_CIN])), .node_out(cin_f)
  );

  for (genvar i = 0; i < GRP_BITS; i++) begin : g_in
    cla_fi_site u_p (
      .node_true(prop[i]), .node_swap(~prop[i]),
      .mode(fault_mode_e'(modes[S_P0+i])), .node_out(p_f[i])
    );
    cla_fi_site u_g (
      .node_true(gen[i]), .node_swap(~gen[i]),
      .mode(fault_mode_e'(modes[S_G0+i])), .node_out(g_f[i])
    );
  end

  cla_fi_site u_term (
    .node_true(p_f[1] & g_f[0]), .node_swap(p_f[1] | g_f[0]),
    .mode(fault_mode_e'(modes[S_TERM])), .node_out(term_f)
  );

  assign c_or[0] = g_f[0] | (p_f[0] & cin_f);
  assign c_or[1] = g_f[1] | term_f | (p_f[1] & p_f[0] & cin_f);
  assign c_or[2] = g_f[2] | (p_f[2] & g_f[1]) | (p_f[2] & p_f[1] & g_f[0])
                 | ((&p_f[2:0]) & cin_f);
  assign gg_or   = g_f[3] | (p_f[3] & g_f[2]) | ((&p_f[3:2]) & g_f[1])
                 | ((&p_f[3:1]) & g_f[0]);
  assign gp_and  = &p_f;
  assign gp_or   = |p_f;

  for (genvar k = 0; k < 3; k++) begin : g_carry
    cla_fi_site u_c (
      .node_true(c_or[k]), .node_swap(~c_or[k]),
      .mode(fault_mode_e'(modes[S_C1+k])), .node_out(carry[k])
    );
  end

  cla_fi_site u_gp (
    .node_true(gp_and), .node_swap(gp_or),
    .mode(fault_mode_e'(modes[S_GP])), .node_out(gprop)
  );
  cla_fi_site u_gg (
    .node_true(gg_or), .node_swap(~gg_or),
    .mode(fault_mode_e'(modes[S_GG])), .node_out(ggen)
  );
endmodule

// File: rtl/cla_fi_top.sv
module cla_fi_top
  import cla_fi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [SITE_AW-1:0] cfg_site,
  input  logic [1:0]         cfg_mode,
  input  logic               carry_in,
  input  logic [3:0]         gen_in,
  input  logic [3:0]         prop_in,
  output logic [2:0]         carry_out,
  output logic               grp_gen,
  output logic               grp_prop
);
  logic [NUM_SITES-1:0][1:0] modes;

  cla_fi_ctrl #(.SITES(NUM_SITES), .AW(SITE_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_site(cfg_site),
    .cfg_mode(cfg_mode), .modes(modes)
  );

  cla_fi_core #(.SITES(NUM_SITES)) u_core (
    .cin(carry_in), .gen(gen_in), .prop(prop_in), .modes(modes),
    .carry(carry_out), .ggen(grp_gen), .gprop(grp_prop)
  );

  logic clean;
  assign clean = (modes == '0);

  assert_clean_c1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clean |-> carry_out[0] == (gen_in[0] | (prop_in[0] & carry_in)));

  assert_clean_gp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clean |-> grp_prop == (prop_in == 4'hF));

  assert_c1_stuck_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (modes[S_C1] == FM_SA0) |-> !carry_out[0]);

  assert_gg_stuck_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (modes[S_GG] == FM_SA1) |-> grp_gen);

  assert_gp_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (modes[S_GP] == FM_SWAP && modes[S_P0+3:S_P0] == '0) |-> grp_prop == (prop_in != 4'h0));
endmodule

// File: tb/cla_fi_top_bench.sv
module cla_fi_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_site = '0;
  logic [1:0] cfg_mode = '0;
  logic       carry_in = 1'b0;
  logic [3:0] gen_in = '0, prop_in = '0;
  logic [2:0] carry_out;
  logic       grp_gen, grp_prop;

  int compared = 0, mismatched = 0;
  int mdl [15];

  always #4 clk = ~clk;

  cla_fi_top u_cla_fi_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_site(cfg_site),
    .cfg_mode(cfg_mode), .carry_in(carry_in), .gen_in(gen_in),
    .prop_in(prop_in), .carry_out(carry_out), .grp_gen(grp_gen),
    .grp_prop(grp_prop)
  );

  function automatic bit ap(int m, bit v, bit sw);
    case (m)
      1: return 1'b0;
      2: return 1'b1;
      3: return sw;
      default: return v;
    endcase
  endfunction

  function automatic bit [4:0] expect_out();
    bit ci, t, x, y, r1, r2, r3, z, all1, any1;
    bit [3:0] p, g;
    ci = ap(mdl[0], carry_in, !carry_in);
    for (int i = 0; i < 4; i++) begin
      p[i] = ap(mdl[1+i], prop_in[i], !prop_in[i]);
      g[i] = ap(mdl[5+i], gen_in[i], !gen_in[i]);
    end
    t  = ap(mdl[14], p[1] & g[0], p[1] | g[0]);
    r1 = g[0] | (p[0] & ci);
    r2 = g[1] | t | (p[1] & p[0] & ci);
    x  = r1;
    y  = g[1] | (p[1] & x);
    r3 = g[2] | (p[2] & y);
    z  = g[0];
    for (int i = 1; i < 4; i++) z = g[i] | (p[i] & z);
    all1 = 1'b1; any1 = 1'b0;
    for (int i = 0; i < 4; i++) begin
      all1 = all1 & p[i];
      any1 = any1 | p[i];
    end
    // {grp_prop, grp_gen, carry3, carry2, carry1}
    return {ap(mdl[12], all1, any1), ap(mdl[13], z, !z),
            ap(mdl[11], r3, !r3), ap(mdl[10], r2, !r2), ap(mdl[9], r1, !r1)};
  endfunction

  task automatic compare(string tag);
    bit [4:0] exp_v, act_v;
    exp_v = expect_out();
    act_v = {grp_prop, grp_gen, carry_out};
    compared++;
    if (act_v !== exp_v) begin
      mismatched++;
      $display("FAIL %s: outputs {gp,gg,c3,c2,c1} got %b expected %b (cin=%b g=%b p=%b)",
               tag, act_v, exp_v, carry_in, gen_in, prop_in);
    end
  endtask

  // one clock: drive after a falling edge, update model at the rising edge,
  // compare at the next falling edge
  task automatic step(bit wr, int site, int mode, bit rnd, bit [8:0] pat, string tag);
    cfg_wr   = wr;
    cfg_site = 4'(site);
    cfg_mode = 2'(mode);
    if (rnd) {carry_in, gen_in, prop_in} = 9'($urandom);
    else     {carry_in, gen_in, prop_in} = pat;
    @(posedge clk);
    if (wr && site <= 14) mdl[site] = mode;
    @(negedge clk);
    cfg_wr = 1'b0;
    compare(tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    summary();
  end

  initial begin
    string tg;
    for (int i = 0; i < 15; i++) mdl[i] = 0;
    @(negedge clk);
    {carry_in, gen_in, prop_in} = 9'h15A;
    #1 compare("R8 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: exhaustive fault-free sweep
    for (int v = 0; v < 512; v++) step(1'b0, 0, 0, 1'b0, 9'(v), "R1 R2 clean sweep");

    // R3 R4 R5 R7: each site in each mode, then restored
    for (int s = 0; s < 15; s++) begin
      for (int m = 1; m < 4; m++) begin
        tg = (m == 1) ? "R3 stuck-0" : (m == 2) ? "R4 stuck-1" : "R5 swap";
        step(1'b1, s, m, 1'b1, '0, tg);
        for (int k = 0; k < 31; k++) step(1'b0, 0, 0, 1'b1, '0, tg);
        step(1'b1, s, 0, 1'b1, '0, "R7 mode cleared");
        step(1'b0, 0, 0, 1'b1, '0, "R7 mode cleared");
      end
    end

    // R6: p0, p3, g0 stuck-1 together
    step(1'b1, 1, 2, 1'b1, '0, "R6 multi");
    step(1'b1, 4, 2, 1'b1, '0, "R6 multi");
    step(1'b1, 5, 2, 1'b1, '0, "R6 multi");
    for (int k = 0; k < 64; k++) step(1'b0, 0, 0, 1'b1, '0, "R6 multi");
    // add gate swaps on top: group generate NOR, term OR
    step(1'b1, 13, 3, 1'b1, '0, "R6 multi swap");
    step(1'b1, 14, 3, 1'b1, '0, "R6 multi swap");
    for (int k = 0; k < 64; k++) step(1'b0, 0, 0, 1'b1, '0, "R6 multi swap");

    // R8: asynchronous reset in the middle of a faulted run
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 15; i++) mdl[i] = 0;
    compare("R8 reset clears faults");
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) step(1'b0, 0, 0, 1'b1, '0, "R8 after reset");

    // R9: spare address 15 must not alter any site
    step(1'b1, 15, 2, 1'b1, '0, "R9 spare address");
    step(1'b1, 15, 1, 1'b1, '0, "R9 spare address");
    for (int k = 0; k < 32; k++) step(1'b0, 0, 0, 1'b1, '0, "R9 spare address");

    summary();
  end
endmodule